// File: doc/BRIEF.md
# Interrupt Request Expander with Vector Generation

This block gathers a small group of active-low interrupt request lines into one active-high interrupt output for a processor. When the processor acknowledges, it issues two low strobes on an acknowledge input. During the second strobe the block places an 8-bit vector type number on the data bus. The low bits of that vector are a snapshot of which request lines were pending when the first strobe began. The high bits come from a host-programmable base. If several lines are pending together, the processor therefore sees a distinct combined vector and can dispatch to a handler that applies its own priority.

A mode input chooses between two request styles. In level mode a line counts as pending only while it is held low. In edge mode each falling edge is captured in a per-line latch. The latch keeps the request alive after the line returns high, and the acknowledge clears only the latches that were captured in its snapshot. A host-written mask suppresses individual lines. A host-written base is refused if it would place any vector inside the reserved range below 20h. The request lines pass through a two-stage synchronizer, so a change on a line reaches the output two clock cycles later.

Top module: `irqx_top`

## Requirements
- R1: In level mode, `intr` is high while at least one unmasked `req_n` line is low and no acknowledge is in progress, and it is low otherwise; it follows a line change within four clock cycles.
- R2: Request lines are active-low. Bit i of the low N_REQ bits of the vector is 1 exactly when line i was pending at the start of the acknowledge.
- R3: In edge mode, a falling edge on an unmasked `req_n` line is latched, and `intr` stays high after the line returns high until an acknowledge captures that line.
- R4: An acknowledge is two low pulses on `inta_n`. `intr` is low in every cycle that follows a cycle in which `inta_n` was low.
- R5: `data_oe` is high only during the second low pulse of `inta_n`. It rises in the cycle after that pulse is sampled and falls in the cycle after `inta_n` is sampled high again. Whenever `data_oe` is low, `data_out` is zero.
- R6: The vector equals base × 2^N_REQ plus the pending pattern sampled in the cycle the first pulse is seen. Simultaneous requests produce the combined pattern, and the value stays steady for the whole second pulse.
- R7: An acknowledge clears only the edge latches included in its snapshot. An edge that arrives during the acknowledge stays pending and raises `intr` again once the acknowledge ends.
- R8: A mask bit of 1 suppresses its line. In edge mode it also discards that line's latch, so unmasking later does not raise `intr`. The mask resets to all zeros.
- R9: The base resets to all ones. A base write that would make the smallest vector fall below 20h is ignored, and a legal write takes effect on the next acknowledge.
- R10: After reset, `intr`, `data_oe` and `data_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | N_REQ | Active-low interrupt request lines |
| edge_mode | input | 1 | 1 = latch falling edges, 0 = level requests |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | N_REQ | New mask, 1 suppresses a line |
| base_we | input | 1 | Base write strobe |
| base_wdata | input | VEC_W-N_REQ | New vector base (upper vector bits) |
| inta_n | input | 1 | Active-low acknowledge strobe from the processor |
| intr | output | 1 | Interrupt request to the processor |
| data_out | output | VEC_W | Vector byte, zero when not driven |
| data_oe | output | 1 | Data bus drive enable for the vector |

## Verification
All 32 request patterns of the default five-line configuration are swept in level mode and again in edge mode. This separates a vector built from the exact pending pattern from one built from a single winning line, and it separates a latch that outlives its line from a level request. A sweep of all 32 masks against a full, an alternating and a sparse request pattern shows which bits the mask removes from both `intr` and the vector. Directed sequences inject an edge in the gap between the acknowledge pulses and write an illegal and then a legal base. These show that a late edge survives the clear and that the reserved vector range cannot be reached.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

  typedef enum logic [1:0] {
    ACK_IDLE   = 2'd0,
    ACK_FIRST  = 2'd1,
    ACK_GAP    = 2'd2,
    ACK_SECOND = 2'd3
  } ack_state_e;

  // lowest vector number open to user handlers
  localparam int unsigned RSV_LIMIT = 32;

endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/irqx_req_src.sv
module irqx_req_src #(
  parameter int N_REQ = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_mode,
  input  logic [N_REQ-1:0] mask,
  input  logic [N_REQ-1:0] act,
  input  logic [N_REQ-1:0] clr,
  output logic [N_REQ-1:0] pend
);

  logic [N_REQ-1:0] act_d_q;
  logic [N_REQ-1:0] lat_q;
  logic [N_REQ-1:0] lat_d;
  logic [N_REQ-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_d_q <= '0;
    else        act_d_q <= act;
  end

  for (genvar i = 0; i < N_REQ; i++) begin : g_line
    // falling edge on the pin is a rising edge of the active-high copy
    assign rise[i] = act[i] & ~act_d_q[i];

    always_comb begin
      if (edge_mode) lat_d[i] = ((lat_q[i] & ~clr[i]) | rise[i]) & ~mask[i];
      else           lat_d[i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q[i] <= 1'b0;
      else        lat_q[i] <= lat_d[i];
    end

    assign pend[i] = (edge_mode ? lat_q[i] : act[i]) & ~mask[i];

    // R7: a captured line with no fresh edge is gone one cycle later
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !rise[i]) |=> !lat_q[i]);

    // R8: a masked line keeps no latched request
    a_r8_mask_discards: assert property (@(posedge clk) disable iff (!rst_n)
      mask[i] |=> !lat_q[i]);
  end

endmodule

// File: rtl/irqx_ack_seq.sv
module irqx_ack_seq
  import irqx_pkg::*;
#(
  parameter int N_REQ = 5,
  parameter int VEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inta_n,
  input  logic [N_REQ-1:0]       pend,
  input  logic [VEC_W-N_REQ-1:0] base,
  output logic [N_REQ-1:0]       clr,
  output logic                   busy,
  output logic                   vec_oe,
  output logic [VEC_W-1:0]       vec_out
);

  ack_state_e       st_q, st_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             capture;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ACK_IDLE:   if (!inta_n) st_d = ACK_FIRST;
      ACK_FIRST:  if (inta_n)  st_d = ACK_GAP;
      ACK_GAP:    if (!inta_n) st_d = ACK_SECOND;
      ACK_SECOND: if (inta_n)  st_d = ACK_IDLE;
      default:                 st_d = ACK_IDLE;
    endcase
  end

  assign capture = (st_q == ACK_IDLE) && !inta_n;

  always_comb begin
    vec_d = vec_q;
    if (capture) vec_d = {base, pend};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ACK_IDLE;
      vec_q <= '0;
    end else begin
      st_q  <= st_d;
      vec_q <= vec_d;
    end
  end

  assign clr     = capture ? pend : '0;
  assign busy    = (st_q != ACK_IDLE);
  assign vec_oe  = (st_q == ACK_SECOND);
  assign vec_out = vec_oe ? vec_q : '0;

  // R5: the bus is enabled only after a low acknowledge was sampled
  a_r5_oe_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_oe) |-> !$past(inta_n));

  // R6: the vector does not move while it is driven
  a_r6_vector_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe && $past(vec_oe)) |-> $stable(vec_out));

endmodule

// File: rtl/irqx_top.sv
module irqx_top
  import irqx_pkg::*;
#(
  parameter int N_REQ = 5,
  parameter int VEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_REQ-1:0]       req_n,
  input  logic                   edge_mode,
  input  logic                   mask_we,
  input  logic [N_REQ-1:0]       mask_wdata,
  input  logic                   base_we,
  input  logic [VEC_W-N_REQ-1:0] base_wdata,
  input  logic                   inta_n,
  output logic                   intr,
  output logic [VEC_W-1:0]       data_out,
  output logic                   data_oe
);

  localparam int BASE_W = VEC_W - N_REQ;
  localparam logic [VEC_W-1:0] RSV_V = VEC_W'(RSV_LIMIT);

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [N_REQ-1:0]  act_s;
  logic [N_REQ-1:0]  pend;
  logic [N_REQ-1:0]  clr;
  logic              busy;
  logic [N_REQ-1:0]  mask_q, mask_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic              base_ok;

  irqx_sync #(.W(N_REQ)) i_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d     (~req_n),
    .q     (act_s)
  );

  assign base_ok = ({base_wdata, {N_REQ{1'b0}}} >= RSV_V);

  always_comb begin
    mask_d = mask_q;
    base_d = base_q;
    if (mask_we)            mask_d = mask_wdata;
    if (base_we && base_ok) base_d = base_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      mask_q <= '0;
      base_q <= '1;
    end else begin
      mask_q <= mask_d;
      base_q <= base_d;
    end
  end

  irqx_req_src #(.N_REQ(N_REQ)) i_src (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .edge_mode (edge_mode),
    .mask      (mask_q),
    .act       (act_s),
    .clr       (clr),
    .pend      (pend)
  );

  irqx_ack_seq #(.N_REQ(N_REQ), .VEC_W(VEC_W)) i_ack (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .inta_n  (inta_n),
    .pend    (pend),
    .base    (base_q),
    .clr     (clr),
    .busy    (busy),
    .vec_oe  (data_oe),
    .vec_out (data_out)
  );

  assign intr = !busy && (|pend);

  // R4: once the processor acknowledges, the request output is withdrawn
  a_r4_intr_quiet_in_ack: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !inta_n |=> !intr);

  // R8: with every line masked nothing can interrupt
  a_r8_all_masked: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (&mask_q) |-> !intr);

  // R9: a driven vector never lies in the reserved range
  a_r9_vector_range: assert property (@(posedge clk) disable iff (!rst_sync_q)
    data_oe |-> (data_out >= RSV_V));

  // R5: the bus carries zero whenever it is not enabled
  a_r5_bus_idle_zero: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !data_oe |-> (data_out == '0));

endmodule

// File: tb/test_irqx_top.sv
module test_irqx_top;

  localparam int N = 5;
  localparam int V = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req_n;
  logic         edge_mode;
  logic         mask_we;
  logic [N-1:0] mask_wdata;
  logic         base_we;
  logic [V-N-1:0] base_wdata;
  logic         inta_n;
  logic         intr;
  logic [V-1:0] data_out;
  logic         data_oe;

  int total = 0;
  int bad   = 0;
  int base  = 7;

  always #5 clk = ~clk;

  irqx_top #(.N_REQ(N), .VEC_W(V)) i_irqx_top (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .edge_mode(edge_mode),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .base_we(base_we),
    .base_wdata(base_wdata), .inta_n(inta_n), .intr(intr),
    .data_out(data_out), .data_oe(data_oe)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_mask(input int m);
    mask_we = 1'b1; mask_wdata = N'(m); tick(); mask_we = 1'b0;
  endtask

  task automatic wr_base(input int b);
    base_we = 1'b1; base_wdata = (V-N)'(b); tick(); base_we = 1'b0;
  endtask

  // full two-pulse acknowledge; returns the vector seen on the bus
  task automatic do_ack(output int vec);
    inta_n = 1'b0; tick();
    chk("R4 intr low in first pulse", int'(intr), 0);
    chk("R5 no drive in first pulse", int'(data_oe), 0);
    inta_n = 1'b1; tick();
    chk("R4 intr low in gap", int'(intr), 0);
    inta_n = 1'b0; tick();
    chk("R5 drive in second pulse", int'(data_oe), 1);
    vec = int'(data_out);
    tick();
    chk("R6 vector steady", int'(data_out), vec);
    inta_n = 1'b1; tick();
    chk("R5 drive released", int'(data_oe), 0);
    chk("R5 bus zero when released", int'(data_out), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vec;
    rst_n = 1'b0; req_n = '1; edge_mode = 1'b0; mask_we = 1'b0;
    mask_wdata = '0; base_we = 1'b0; base_wdata = '0; inta_n = 1'b1;
    tick(3);
    chk("R10 intr at reset", int'(intr), 0);
    chk("R10 oe at reset", int'(data_oe), 0);
    chk("R10 data at reset", int'(data_out), 0);
    rst_n = 1'b1;
    tick(5);

    // R1 R2 R6: level mode, every request pattern
    for (int p = 0; p < 32; p++) begin
      req_n = ~N'(p); tick(4);
      chk("R1 level intr", int'(intr), int'(p != 0));
      do_ack(vec);
      chk("R2 R6 level vector", vec, base * 32 + p);
      chk("R1 level intr after ack", int'(intr), int'(p != 0));
      req_n = '1; tick(4);
      chk("R1 intr drops on release", int'(intr), 0);
    end

    // R8: every mask against three patterns
    for (int m = 0; m < 32; m++) begin
      wr_mask(m);
      for (int k = 0; k < 3; k++) begin
        int p;
        p = (k == 0) ? 31 : (k == 1) ? 21 : 10;
        req_n = ~N'(p); tick(4);
        chk("R8 masked intr", int'(intr), int'((p & ~m & 31) != 0));
        do_ack(vec);
        chk("R8 masked vector", vec, base * 32 + (p & ~m & 31));
        req_n = '1; tick(4);
      end
    end
    wr_mask(0);

    // R3 R7: edge mode, every pattern as short pulses
    edge_mode = 1'b1; tick(4);
    chk("R3 edge idle", int'(intr), 0);
    for (int p = 1; p < 32; p++) begin
      req_n = ~N'(p); tick(3);
      req_n = '1; tick(4);
      chk("R3 edge latched after release", int'(intr), 1);
      do_ack(vec);
      chk("R3 R6 edge vector", vec, base * 32 + p);
      tick();
      chk("R7 latches cleared", int'(intr), 0);
    end

    // R7: an edge arriving during the acknowledge survives it
    req_n = 5'b11110; tick(3); req_n = '1; tick(4);
    inta_n = 1'b0; tick();
    inta_n = 1'b1; req_n = 5'b11101; tick(3);
    req_n = '1;
    inta_n = 1'b0; tick();
    chk("R5 late edge drive", int'(data_oe), 1);
    chk("R7 late edge not in vector", int'(data_out), base * 32 + 1);
    inta_n = 1'b1; tick(2);
    chk("R7 late edge raises intr", int'(intr), 1);
    do_ack(vec);
    chk("R7 late edge vector", vec, base * 32 + 2);
    tick();
    chk("R7 all cleared", int'(intr), 0);

    // R8: a masked edge is discarded
    wr_mask(1);
    req_n = 5'b11110; tick(3); req_n = '1; tick(4);
    chk("R8 masked edge", int'(intr), 0);
    wr_mask(0); tick(2);
    chk("R8 masked edge discarded", int'(intr), 0);

    // R9: base protection and update
    edge_mode = 1'b0; tick(4);
    wr_base(0);
    req_n = 5'b11110; tick(4);
    do_ack(vec);
    chk("R9 reserved base refused", vec, 7 * 32 + 1);
    wr_base(1); base = 1;
    do_ack(vec);
    chk("R9 legal base taken", vec, 32 + 1);
    req_n = '1; tick(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule